// File: doc/BRIEF.md
# Double-Buffered Octal DAC Register Controller

This block sits between a two-wire slave front end and an eight-channel analog converter. The front end has already matched the device address. It hands this block each following byte as a one-cycle strobe with data. It also gives a one-cycle pulse for each START or repeated START and a one-cycle pulse for a STOP that closes a session addressed to this device. Bytes after the address alternate between a command byte and an output byte. Output bytes land in a bank of eight staging registers, and nothing reaches the converter until a STOP.

On STOP the whole staging bank is copied into the live bank in one clock, so all eight channel codes change together. The same STOP applies the power-down request carried by the last command byte of the session. A command byte can also clear every staging register at once. A byte cut short by a STOP never reaches this block, so an interrupted command simply has no effect. An interrupted output byte leaves its command's power-down and clear bits in force.

Top module: `odac_regs`

## Requirements
- R1: After reset, all eight channel codes on `dac_codes` are 0x00 and `pwr_down` is 0.
- R2: The first accepted byte after a START is a command. Accepted bytes then alternate command, output, command, and so on. In a command byte, bits [2:0] select channel 0..7, bit 3 is the power-down request, bit 4 is the clear request, and bits [7:5] are ignored. An output byte is stored in the staging register of the channel named by the command before it.
- R3: `dac_codes` changes only in the cycle after a `stop_evt` pulse. It then holds all eight staging registers, so several channels written in one session change together. Channel n occupies `dac_codes[8n+7:8n]`.
- R4: A command byte with bit 4 set clears all staging registers at once, and the output byte that follows it is discarded. Later command/output pairs in the same session write the staging registers again.
- R5: At STOP, `pwr_down` takes bit 3 of the last command byte accepted in the session. Between STOPs it does not change, and the live codes are kept while powered down.
- R6: A command byte with no output byte after it, before the STOP, writes no staging register but still supplies its power-down and clear bits.
- R7: A START pulse restarts the command/output alternation and keeps staged data uncommitted until a later STOP.
- R8: A byte strobe in the same cycle as `start_evt` or `stop_evt` is ignored.
- R9: A STOP in a session with no command byte still copies the staging registers to the live codes and leaves `pwr_down` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| byte_vld | input | 1 | One-cycle strobe for a received byte |
| byte_data | input | 8 | Received byte |
| start_evt | input | 1 | One-cycle pulse on START or repeated START |
| stop_evt | input | 1 | One-cycle pulse on STOP of a session addressed to this device |
| dac_codes | output | 64 | Live codes, channel n in bits [8n+7:8n] |
| pwr_down | output | 1 | Power-down level for the analog back end |

## Verification
Some rules are checked by the assertions on every cycle. The live codes and the power-down level hold between STOPs, and a STOP copies the staging bank exactly. A clear command empties the staging bank in the next cycle. A START or STOP cycle leaves the staging bank untouched. Other rules can only be shown by the bench's scenarios over whole byte sequences. These are the byte alternation, the discarded byte after a clear, last-command-wins for power-down, the restart after a repeated START, and a STOP with no command.

// File: rtl/odac_pkg.sv
package odac_pkg;
  localparam int unsigned CH_NUM  = 8;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned SYNC_FF = 2;
endpackage

// File: rtl/odac_cmd_seq.sv
module odac_cmd_seq #(
  parameter int unsigned N_CH   = odac_pkg::CH_NUM,
  parameter int unsigned BYTE_W = odac_pkg::BYTE_W,
  localparam int unsigned SEL_W   = $clog2(N_CH),
  localparam int unsigned PD_POS  = SEL_W,
  localparam int unsigned CLR_POS = SEL_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              start_evt,
  input  logic              stop_evt,
  output logic              wr_en,
  output logic [SEL_W-1:0]  wr_sel,
  output logic [BYTE_W-1:0] wr_data,
  output logic              clr_all,
  output logic              commit,
  output logic              pwr_down,
  output logic              data_phase
);
  logic             phase_q, phase_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic             drop_q, drop_d;
  logic             pdreq_q, pdreq_d;
  logic             seen_q, seen_d;
  logic             pd_q, pd_d;
  logic             byte_ok, is_cmd, is_dat;

  always_comb begin
    byte_ok = byte_vld & ~stop_evt & ~start_evt;
    is_cmd  = byte_ok & ~phase_q;
    is_dat  = byte_ok & phase_q;

    phase_d = phase_q;
    sel_d   = sel_q;
    drop_d  = drop_q;
    pdreq_d = pdreq_q;
    seen_d  = seen_q;
    pd_d    = pd_q;

    if (stop_evt && seen_q) begin
      pd_d = pdreq_q;
    end
    if (stop_evt || start_evt) begin
      phase_d = 1'b0;
      drop_d  = 1'b0;
      seen_d  = 1'b0;
    end
    if (is_cmd) begin
      sel_d   = byte_data[SEL_W-1:0];
      pdreq_d = byte_data[PD_POS];
      drop_d  = byte_data[CLR_POS];
      seen_d  = 1'b1;
      phase_d = 1'b1;
    end
    if (is_dat) begin
      phase_d = 1'b0;
      drop_d  = 1'b0;
    end

    wr_en   = is_dat & ~drop_q;
    wr_sel  = sel_q;
    wr_data = byte_data;
    clr_all = is_cmd & byte_data[CLR_POS];
    commit  = stop_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      sel_q   <= '0;
      drop_q  <= 1'b0;
      pdreq_q <= 1'b0;
      seen_q  <= 1'b0;
      pd_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      drop_q  <= drop_d;
      seen_q  <= seen_d;
      pd_q    <= pd_d;
      if (is_cmd) begin
        sel_q   <= sel_d;
        pdreq_q <= pdreq_d;
      end
    end
  end

  assign pwr_down   = pd_q;
  assign data_phase = phase_q;
endmodule

// File: rtl/odac_stage_bank.sv
module odac_stage_bank #(
  parameter int unsigned N_CH   = odac_pkg::CH_NUM,
  parameter int unsigned BYTE_W = odac_pkg::BYTE_W,
  localparam int unsigned SEL_W = $clog2(N_CH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [SEL_W-1:0]         wr_sel,
  input  logic [BYTE_W-1:0]        wr_data,
  input  logic                     clr_all,
  output logic [N_CH*BYTE_W-1:0]   stage_flat
);
  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    logic [BYTE_W-1:0] q, d;
    logic              en;

    always_comb begin
      en = clr_all | (wr_en && (wr_sel == SEL_W'(ch)));
      d  = clr_all ? '0 : wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (en) begin
        q <= d;
      end
    end

    assign stage_flat[ch*BYTE_W +: BYTE_W] = q;
  end
endmodule

// File: rtl/odac_live_bank.sv
module odac_live_bank #(
  parameter int unsigned N_CH   = odac_pkg::CH_NUM,
  parameter int unsigned BYTE_W = odac_pkg::BYTE_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   commit,
  input  logic [N_CH*BYTE_W-1:0] stage_flat,
  output logic [N_CH*BYTE_W-1:0] live_flat
);
  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    logic [BYTE_W-1:0] q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (commit) begin
        q <= stage_flat[ch*BYTE_W +: BYTE_W];
      end
    end

    assign live_flat[ch*BYTE_W +: BYTE_W] = q;
  end
endmodule

// File: rtl/odac_regs.sv
module odac_regs #(
  parameter int unsigned N_CH   = odac_pkg::CH_NUM,
  parameter int unsigned BYTE_W = odac_pkg::BYTE_W,
  localparam int unsigned SEL_W  = $clog2(N_CH),
  localparam int unsigned SYNC_N = odac_pkg::SYNC_FF
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   byte_vld,
  input  logic [BYTE_W-1:0]      byte_data,
  input  logic                   start_evt,
  input  logic                   stop_evt,
  output logic [N_CH*BYTE_W-1:0] dac_codes,
  output logic                   pwr_down
);
  logic [SYNC_N-1:0]      rst_pipe;
  logic                   rst_sync_n;
  logic                   wr_en, clr_all, commit, data_phase;
  logic [SEL_W-1:0]       wr_sel;
  logic [BYTE_W-1:0]      wr_data;
  logic [N_CH*BYTE_W-1:0] stage_flat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[SYNC_N-2:0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[SYNC_N-1];

  odac_cmd_seq #(.N_CH(N_CH), .BYTE_W(BYTE_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .byte_vld   (byte_vld),
    .byte_data  (byte_data),
    .start_evt  (start_evt),
    .stop_evt   (stop_evt),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .clr_all    (clr_all),
    .commit     (commit),
    .pwr_down   (pwr_down),
    .data_phase (data_phase)
  );

  odac_stage_bank #(.N_CH(N_CH), .BYTE_W(BYTE_W)) u_stage (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .clr_all    (clr_all),
    .stage_flat (stage_flat)
  );

  odac_live_bank #(.N_CH(N_CH), .BYTE_W(BYTE_W)) u_live (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .commit     (commit),
    .stage_flat (stage_flat),
    .live_flat  (dac_codes)
  );
endmodule

// File: rtl/odac_regs_chk.sv
module odac_regs_chk #(
  parameter int unsigned N_CH   = odac_pkg::CH_NUM,
  parameter int unsigned BYTE_W = odac_pkg::BYTE_W,
  localparam int unsigned CLR_POS = $clog2(N_CH) + 1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   byte_vld,
  input logic [BYTE_W-1:0]      byte_data,
  input logic                   start_evt,
  input logic                   stop_evt,
  input logic [N_CH*BYTE_W-1:0] dac_codes,
  input logic                   pwr_down,
  input logic [N_CH*BYTE_W-1:0] stage_flat,
  input logic                   data_phase
);
  AST_LIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_evt |=> $stable(dac_codes)); // R3

  AST_LIVE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (dac_codes == $past(stage_flat))); // R3

  AST_PD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_evt |=> $stable(pwr_down)); // R5

  AST_CLR_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && !stop_evt && !start_evt && !data_phase && byte_data[CLR_POS])
      |=> (stage_flat == '0)); // R4

  AST_EVT_BYTE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_evt || start_evt) |=> $stable(stage_flat)); // R8

  AST_START_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !data_phase); // R7
endmodule

bind odac_regs odac_regs_chk #(.N_CH(N_CH), .BYTE_W(BYTE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .byte_vld   (byte_vld),
  .byte_data  (byte_data),
  .start_evt  (start_evt),
  .stop_evt   (stop_evt),
  .dac_codes  (dac_codes),
  .pwr_down   (pwr_down),
  .stage_flat (stage_flat),
  .data_phase (data_phase)
);

// File: tb/tb_odac_regs.sv
module tb_odac_regs;
  logic        clk;
  logic        rst_n;
  logic        byte_vld;
  logic [7:0]  byte_data;
  logic        start_evt;
  logic        stop_evt;
  logic [63:0] dac_codes;
  logic        pwr_down;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  odac_regs dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_vld  (byte_vld),
    .byte_data (byte_data),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .dac_codes (dac_codes),
    .pwr_down  (pwr_down)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {command byte, output byte, channel}
  localparam logic [19:0] VEC [0:5] = '{
    {8'h00, 8'hA5, 4'd0},
    {8'h03, 8'h3C, 4'd3},
    {8'h07, 8'hFF, 4'd7},
    {8'h05, 8'h01, 4'd5},
    {8'h01, 8'h80, 4'd1},
    {8'hE6, 8'h5A, 4'd6}
  };

  function automatic logic [7:0] code(input int ch);
    return dac_codes[ch*8 +: 8];
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic put_byte(input logic [7:0] b);
    @(negedge clk); byte_vld = 1'b1; byte_data = b;
    @(negedge clk); byte_vld = 1'b0;
  endtask

  task automatic do_start();
    @(negedge clk); start_evt = 1'b1;
    @(negedge clk); start_evt = 1'b0;
  endtask

  task automatic do_stop();
    @(negedge clk); stop_evt = 1'b1;
    @(negedge clk); stop_evt = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; byte_vld = 1'b0; byte_data = 8'h00;
    start_evt = 1'b0; stop_evt = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int ch = 0; ch < 8; ch++) chk("R1 code", code(ch), 8'h00);
    chk("R1 pwr_down", {7'd0, pwr_down}, 8'h00);

    // R2/R3 table walk, one pair per session
    for (int i = 0; i < 6; i++) begin
      logic [7:0] prev;
      prev = code(int'(VEC[i][3:0]));
      do_start();
      put_byte(VEC[i][19:12]);
      put_byte(VEC[i][11:4]);
      chk("R3 held before stop", code(int'(VEC[i][3:0])), prev);
      do_stop();
      chk("R2 pair stored", code(int'(VEC[i][3:0])), VEC[i][11:4]);
    end
    chk("R2 untouched ch2", code(2), 8'h00);

    // R3 two channels change together
    do_start();
    put_byte(8'h02); put_byte(8'h11);
    put_byte(8'h04); put_byte(8'h22);
    chk("R3 ch2 staged only", code(2), 8'h00);
    chk("R3 ch4 staged only", code(4), 8'h00);
    do_stop();
    chk("R3 ch2 commit", code(2), 8'h11);
    chk("R3 ch4 commit", code(4), 8'h22);

    // R4 clear, discarded byte, later pair rewrites
    do_start();
    put_byte(8'h10); put_byte(8'hEE);
    put_byte(8'h01); put_byte(8'h77);
    chk("R3 ch7 before stop", code(7), 8'hFF);
    do_stop();
    chk("R4 ch0 discarded", code(0), 8'h00);
    chk("R4 ch7 cleared", code(7), 8'h00);
    chk("R4 ch6 cleared", code(6), 8'h00);
    chk("R4 ch1 rewritten", code(1), 8'h77);

    // R5 power-down with a pair; codes kept
    do_start();
    put_byte(8'h0A); put_byte(8'h33);
    chk("R5 pd before stop", {7'd0, pwr_down}, 8'h00);
    do_stop();
    chk("R5 pd set", {7'd0, pwr_down}, 8'h01);
    chk("R5 code kept in pd", code(2), 8'h33);

    // R5 last command wins
    do_start();
    put_byte(8'h0C); put_byte(8'h12);
    put_byte(8'h05); put_byte(8'h66);
    do_stop();
    chk("R5 last cmd pd=0", {7'd0, pwr_down}, 8'h00);
    chk("R5 ch4", code(4), 8'h12);
    chk("R5 ch5", code(5), 8'h66);

    // R6 lone trailing command
    do_start();
    put_byte(8'h0B);
    do_stop();
    chk("R6 lone pd", {7'd0, pwr_down}, 8'h01);
    chk("R6 no write ch3", code(3), 8'h00);

    // R9 STOP with no command keeps pd
    do_start();
    do_stop();
    chk("R9 pd unchanged", {7'd0, pwr_down}, 8'h01);

    do_start();
    put_byte(8'h07); put_byte(8'hAB);
    do_stop();
    chk("R5 pd cleared", {7'd0, pwr_down}, 8'h00);
    chk("R5 ch7", code(7), 8'hAB);

    // R7 repeated START keeps staged data uncommitted
    do_start();
    put_byte(8'h00); put_byte(8'h9C);
    do_start();
    chk("R7 uncommitted", code(0), 8'h00);
    do_start();
    put_byte(8'h06); put_byte(8'h4D);
    do_stop();
    chk("R7 later commit ch0", code(0), 8'h9C);
    chk("R7 later commit ch6", code(6), 8'h4D);

    // R7 phase restarts after START
    do_start();
    put_byte(8'h01);
    do_start();
    put_byte(8'h03); put_byte(8'h3D);
    do_stop();
    chk("R7 phase ch1", code(1), 8'h77);
    chk("R7 phase ch3", code(3), 8'h3D);

    // R9 commit with no command
    do_start();
    put_byte(8'h02); put_byte(8'hC3);
    do_start();
    do_stop();
    chk("R9 commit ch2", code(2), 8'hC3);
    chk("R9 pd", {7'd0, pwr_down}, 8'h00);

    // R8 byte with stop ignored
    do_start();
    put_byte(8'h05);
    @(negedge clk); byte_vld = 1'b1; byte_data = 8'h99; stop_evt = 1'b1;
    @(negedge clk); byte_vld = 1'b0; stop_evt = 1'b0;
    chk("R8 byte with stop", code(5), 8'h66);

    // R8 byte with start ignored
    @(negedge clk); byte_vld = 1'b1; byte_data = 8'h07; start_evt = 1'b1;
    @(negedge clk); byte_vld = 1'b0; start_evt = 1'b0;
    put_byte(8'h21); put_byte(8'h62);
    do_stop();
    chk("R8 byte with start ch1", code(1), 8'h62);
    chk("R8 byte with start ch7", code(7), 8'hAB);

    // R6/R4 STOP cuts the output byte after a clear+pd command
    do_start();
    put_byte(8'h18);
    do_stop();
    for (int ch = 0; ch < 8; ch++) chk("R4 early stop clear", code(ch), 8'h00);
    chk("R6 early stop pd", {7'd0, pwr_down}, 8'h01);

    do_start();
    put_byte(8'h00);
    do_stop();
    chk("R6 pd off", {7'd0, pwr_down}, 8'h00);

    finish_run();
  end
endmodule